// File: doc/BRIEF.md
# Packed Multiply-Low Execution Unit

This execution unit multiplies two vectors of packed 32-bit integers lane by lane. For each lane it keeps only the lower 32 bits of the product. A lane's lower 32 bits do not depend on whether the operands are read as signed or unsigned, so one plain truncating multiplier per lane serves every input, including the most negative value. Each request also carries a mode select and a vector-length bit. These decide how many lanes are computed and what lands in the upper half of the 256-bit result. The upper half is taken from the prior destination value, forced to zero, or filled with four more computed lanes.

Requests enter with a one-cycle valid and leave exactly two cycles later. A new request may be accepted on every cycle. The unit flags a request it cannot execute with an undefined-operation pulse, and the result port keeps its previous value for that request. The unit produces no arithmetic status.

Top module: `mullo_simd_unit`

## Requirements
- R1: Each result lane i (bits [32*i+31:32*i]) equals the lower 32 bits of the full 64-bit signed product of lane i of `in_src_a` and lane i of `in_src_b`. For example, 0x80000000 times 0xFFFFFFFF gives 0x80000000, and 0x7FFFFFFF times 0x7FFFFFFF gives 0x00000001.
- R2: With `in_mode` = 2'b10 (wide mode), all eight lanes (bits 255:0) are computed products.
- R3: With `in_mode` = 2'b00 (legacy narrow mode), lanes 0 to 3 are products, and bits [255:128] equal bits [255:128] of `in_prior` from the same request.
- R4: With `in_mode` = 2'b01 (extended narrow mode) and `in_vlen` = 0, lanes 0 to 3 are products and bits [255:128] are zero.
- R5: `out_valid` is high exactly two cycles after a legal request's `in_valid`. Requests on consecutive cycles each produce their own result on consecutive cycles.
- R6: A request with `in_mode` = 2'b11, or with `in_mode` = 2'b01 and `in_vlen` = 1, raises `out_undef` for one cycle two cycles later. In that cycle `out_valid` stays low and `out_result` keeps its previous value.
- R7: While `rst_n` is low at a clock edge, `out_valid`, `out_undef` and `out_result` are cleared to zero (synchronous, active-low).
- R8: `in_vlen` has no effect in modes 2'b00 and 2'b10.
- R9: Cycles without `in_valid` produce neither `out_valid` nor `out_undef`, and `out_result` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | 00 legacy narrow, 01 extended narrow, 10 wide, 11 undefined |
| in_vlen | input | 1 | Vector-length bit; illegal when set in mode 01 |
| in_src_a | input | 256 | First packed source |
| in_src_b | input | 256 | Second packed source |
| in_prior | input | 256 | Prior destination value |
| out_valid | output | 1 | Result strobe |
| out_undef | output | 1 | Undefined-operation pulse |
| out_result | output | 256 | Packed low products |

## Verification
A legal result and an undefined-operation report can reach the output in neighbouring cycles, and the unit must keep the result from being overwritten while the illegal request passes through. The bench issues a legal wide request and, in the very next cycle, an illegal one. It expects the legal result with `out_valid` in the first output cycle. In the following cycle it expects `out_undef` high, `out_valid` low, and `out_result` still equal to the legal result. The same pair is run with the reserved mode code, and again with the vector-length violation.

// File: rtl/mullo_pkg.sv
// Package: shared widths, mode codes and pipeline control record for the
// packed multiply-low unit. Assumes 32-bit lanes in a 256-bit vector.
package mullo_pkg;
    localparam int LANE_W = 32;
    localparam int LANES  = 8;
    localparam int VEC_W  = LANE_W * LANES;
    localparam int HALF_W = VEC_W / 2;

    typedef enum logic [1:0] {
        MODE_LEGACY_N = 2'b00,
        MODE_EXT_N    = 2'b01,
        MODE_WIDE     = 2'b10,
        MODE_RSVD     = 2'b11
    } mode_e;

    typedef struct packed {
        logic  ok;
        logic  bad;
        mode_e mode;
    } ctl_t;
endpackage

// File: rtl/mullo_lane.sv
// Module: one lane multiplier returning only the low LANE_W bits.
// Assumes the low half of a product is identical for signed and unsigned
// operands, so an unsigned truncating multiply is sufficient.
module mullo_lane #(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] lo
);
    // Truncating product of the two lane operands.
    assign lo = a * b;
endmodule

// File: rtl/mullo_prod_stage.sv
// Module: first pipeline stage. Classifies the request as legal or
// undefined, computes all lane low-products and registers them together
// with the upper half of the prior value. Assumes synchronous active-low
// reset; data registers load only on an accepted request.
module mullo_prod_stage
    import mullo_pkg::*;
#(
    parameter int LANE_W = mullo_pkg::LANE_W,
    parameter int LANES  = mullo_pkg::LANES,
    localparam int VEC_W  = LANE_W * LANES,
    localparam int HALF_W = VEC_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_mode,
    input  logic              in_vlen,
    input  logic [VEC_W-1:0]  in_src_a,
    input  logic [VEC_W-1:0]  in_src_b,
    input  logic [VEC_W-1:0]  in_prior,
    output ctl_t              s1_ctl,
    output logic [VEC_W-1:0]  s1_prod,
    output logic [HALF_W-1:0] s1_prior_hi
);
    logic [VEC_W-1:0] prod_c;
    logic             illegal_c;
    mode_e            mode_c;

    // Lane multipliers, one per packed element.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        mullo_lane #(.LANE_W(LANE_W)) u_lane (
            .a  (in_src_a[i*LANE_W +: LANE_W]),
            .b  (in_src_b[i*LANE_W +: LANE_W]),
            .lo (prod_c[i*LANE_W +: LANE_W])
        );
    end

    // Decode the mode and flag reserved code or length-bit violation.
    always_comb begin
        mode_c    = mode_e'(in_mode);
        illegal_c = (mode_c == MODE_RSVD) || ((mode_c == MODE_EXT_N) && in_vlen);
    end

    // Register control for every cycle; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_ctl <= '0;
        end else begin
            s1_ctl.ok   <= in_valid && !illegal_c;
            s1_ctl.bad  <= in_valid && illegal_c;
            s1_ctl.mode <= mode_c;
        end
    end

    // Capture products and prior upper half only for a legal request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_prod     <= '0;
            s1_prior_hi <= '0;
        end else if (in_valid && !illegal_c) begin
            s1_prod     <= prod_c;
            s1_prior_hi <= in_prior[VEC_W-1:HALF_W];
        end
    end
endmodule

// File: rtl/mullo_merge_stage.sv
// Module: second pipeline stage. Chooses the upper half of the result by
// mode (prior value, zeros or computed lanes) and registers the output.
// Assumes the stage-one record is already classified; an undefined
// request only pulses the flag and leaves the result register untouched.
module mullo_merge_stage
    import mullo_pkg::*;
#(
    parameter int LANE_W = mullo_pkg::LANE_W,
    parameter int LANES  = mullo_pkg::LANES,
    localparam int VEC_W  = LANE_W * LANES,
    localparam int HALF_W = VEC_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              s1_ctl,
    input  logic [VEC_W-1:0]  s1_prod,
    input  logic [HALF_W-1:0] s1_prior_hi,
    output logic              out_valid,
    output logic              out_undef,
    output logic [VEC_W-1:0]  out_result
);
    logic [HALF_W-1:0] hi_c;

    // Upper-half source select by encoding mode.
    always_comb begin
        unique case (s1_ctl.mode)
            MODE_LEGACY_N: hi_c = s1_prior_hi;
            MODE_WIDE:     hi_c = s1_prod[VEC_W-1:HALF_W];
            default:       hi_c = '0;
        endcase
    end

    // Output strobes follow the stage-one record each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_undef <= 1'b0;
        end else begin
            out_valid <= s1_ctl.ok;
            out_undef <= s1_ctl.bad;
        end
    end

    // Result register loads only on a legal request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
        end else if (s1_ctl.ok) begin
            out_result <= {hi_c, s1_prod[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/mullo_simd_unit.sv
// Module: packed multiply-low execution unit, top level. Two-stage
// pipeline: product stage, then merge stage. Accepts one request per
// cycle, latency two. Assumes synchronous active-low reset and that
// operand fetch and write-back are handled outside.
module mullo_simd_unit
    import mullo_pkg::*;
#(
    parameter int LANE_W = mullo_pkg::LANE_W,
    parameter int LANES  = mullo_pkg::LANES,
    localparam int VEC_W  = LANE_W * LANES,
    localparam int HALF_W = VEC_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_mode,
    input  logic             in_vlen,
    input  logic [VEC_W-1:0] in_src_a,
    input  logic [VEC_W-1:0] in_src_b,
    input  logic [VEC_W-1:0] in_prior,
    output logic             out_valid,
    output logic             out_undef,
    output logic [VEC_W-1:0] out_result
);
    ctl_t              s1_ctl;
    logic [VEC_W-1:0]  s1_prod;
    logic [HALF_W-1:0] s1_prior_hi;

    mullo_prod_stage #(.LANE_W(LANE_W), .LANES(LANES)) u_prod (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_mode     (in_mode),
        .in_vlen     (in_vlen),
        .in_src_a    (in_src_a),
        .in_src_b    (in_src_b),
        .in_prior    (in_prior),
        .s1_ctl      (s1_ctl),
        .s1_prod     (s1_prod),
        .s1_prior_hi (s1_prior_hi)
    );

    mullo_merge_stage #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
        .clk         (clk),
        .rst_n       (rst_n),
        .s1_ctl      (s1_ctl),
        .s1_prod     (s1_prod),
        .s1_prior_hi (s1_prior_hi),
        .out_valid   (out_valid),
        .out_undef   (out_undef),
        .out_result  (out_result)
    );
endmodule

// File: rtl/mullo_simd_unit_chk.sv
// Module: property checker for the packed multiply-low unit, attached to
// the top level by bind. Observes ports only.
module mullo_simd_unit_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [1:0]   in_mode,
    input logic         in_vlen,
    input logic [255:0] in_src_a,
    input logic [255:0] in_src_b,
    input logic [255:0] in_prior,
    input logic         out_valid,
    input logic         out_undef,
    input logic [255:0] out_result
);
    logic               req_bad;
    logic               req_ok;
    logic signed [63:0] p0;
    logic signed [63:0] p7;

    // Reference view of the request class and of two lane products.
    always_comb begin
        req_bad = (in_mode == 2'b11) || ((in_mode == 2'b01) && in_vlen);
        req_ok  = in_valid && !req_bad;
        p0      = $signed(in_src_a[31:0])    * $signed(in_src_b[31:0]);
        p7      = $signed(in_src_a[255:224]) * $signed(in_src_b[255:224]);
    end

    assert_lane0_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ok |-> ##2 (out_result[31:0] == $past(p0[31:0], 2)));

    assert_wide_top_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ok && in_mode == 2'b10) |-> ##2 (out_result[255:224] == $past(p7[31:0], 2)));

    assert_legacy_keeps_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ok && in_mode == 2'b00) |-> ##2 (out_result[255:128] == $past(in_prior[255:128], 2)));

    assert_ext_zero_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ok && in_mode == 2'b01) |-> ##2 (out_result[255:128] == 128'd0));

    assert_latency_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ok |-> ##2 out_valid);

    assert_undef_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && req_bad) |-> ##2 (out_undef && !out_valid));

    assert_undef_holds_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> $stable(out_result));

    assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_valid, out_undef}));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 (!out_valid && !out_undef));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(rst_n)) |-> $stable(out_result));
endmodule

bind mullo_simd_unit mullo_simd_unit_chk u_chk (.*);

// File: tb/mullo_simd_unit_tb.sv
// Directed bench for the packed multiply-low unit.
module mullo_simd_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [1:0]   in_mode;
    logic         in_vlen;
    logic [255:0] in_src_a;
    logic [255:0] in_src_b;
    logic [255:0] in_prior;
    logic         out_valid;
    logic         out_undef;
    logic [255:0] out_result;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mullo_simd_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_vlen(in_vlen), .in_src_a(in_src_a), .in_src_b(in_src_b),
        .in_prior(in_prior), .out_valid(out_valid), .out_undef(out_undef),
        .out_result(out_result)
    );

    // Expected result from the requirements.
    function automatic logic [255:0] ref_res(input logic [1:0] m, input logic [255:0] a,
                                             input logic [255:0] b, input logic [255:0] pr);
        logic [255:0] r;
        for (int i = 0; i < 8; i++) begin
            logic signed [63:0] p;
            p = $signed(a[32*i +: 32]) * $signed(b[32*i +: 32]);
            r[32*i +: 32] = p[31:0];
        end
        if (m == 2'b00) r[255:128] = pr[255:128];
        else if (m == 2'b01) r[255:128] = '0;
        return r;
    endfunction

    function automatic logic [255:0] pattern(input int seed);
        logic [255:0] v;
        for (int i = 0; i < 8; i++) begin
            v[32*i +: 32] = 32'(seed * 32'h9E3779B1 + i * 32'h7F4A7C15) ^ 32'(seed << (i + 3));
        end
        return v;
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] m, input logic vl,
                         input logic [255:0] a, input logic [255:0] b, input logic [255:0] pr);
        in_valid = v; in_mode = m; in_vlen = vl;
        in_src_a = a; in_src_b = b; in_prior = pr;
    endtask

    // One request, idle afterwards; checked two edges later.
    task automatic one_op(input string req, input logic [1:0] m, input logic vl,
                          input logic [255:0] a, input logic [255:0] b, input logic [255:0] pr);
        @(negedge clk); drive(1'b1, m, vl, a, b, pr);
        @(negedge clk); drive(1'b0, 2'b00, 1'b0, '0, '0, '0);
        @(negedge clk);
        chk({req, " valid"}, {255'd0, out_valid}, 256'd1);
        chk({req, " result"}, out_result, ref_res(m, a, b, pr));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        drive(1'b1, 2'b10, 1'b0, pattern(1), pattern(2), '0);
        repeat (3) @(negedge clk);
        chk("R7 valid", {255'd0, out_valid}, '0);
        chk("R7 undef", {255'd0, out_undef}, '0);
        chk("R7 result", out_result, '0);
        drive(1'b0, 2'b00, 1'b0, '0, '0, '0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_corner_r1();
        logic [255:0] a, b;
        a = {32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h00000000,
             32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000};
        b = {32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h12345678,
             32'h00000002, 32'hFFFFFFFF, 32'h00000005, 32'hFFFFFFFF};
        one_op("R1 corner", 2'b10, 1'b0, a, b, pattern(9));
        chk("R1 lane0 min*-1", {224'd0, out_result[31:0]}, 256'h80000000);
        chk("R1 lane7 max*max", {224'd0, out_result[255:224]}, 256'h1);
    endtask

    task automatic t_wide_r2();
        for (int s = 3; s < 6; s++) one_op("R2 wide", 2'b10, 1'b0, pattern(s), pattern(s + 40), pattern(s + 80));
        one_op("R8 wide vlen", 2'b10, 1'b1, pattern(11), pattern(12), pattern(13));
    endtask

    task automatic t_legacy_r3();
        one_op("R3 legacy", 2'b00, 1'b0, pattern(21), pattern(22), pattern(23));
        one_op("R8 legacy vlen", 2'b00, 1'b1, pattern(24), pattern(25), pattern(26));
    endtask

    task automatic t_ext_r4();
        one_op("R4 ext narrow", 2'b01, 1'b0, pattern(31), pattern(32), {256{1'b1}});
    endtask

    task automatic t_stream_r5();
        logic [255:0] a[4], b[4], p[4];
        logic [1:0]   m[4];
        for (int k = 0; k < 4; k++) begin
            a[k] = pattern(50 + k); b[k] = pattern(60 + k); p[k] = pattern(70 + k);
            m[k] = 2'(k % 3);
        end
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (c >= 2) begin
                chk("R5 stream valid", {255'd0, out_valid}, 256'd1);
                chk("R5 stream result", out_result, ref_res(m[c-2], a[c-2], b[c-2], p[c-2]));
            end
            if (c < 4) drive(1'b1, m[c], 1'b0, a[c], b[c], p[c]);
            else drive(1'b0, 2'b00, 1'b0, '0, '0, '0);
        end
    endtask

    // Legal request immediately followed by an illegal one.
    task automatic t_undef_r6(input logic [1:0] bad_m, input logic bad_vl);
        logic [255:0] good;
        good = ref_res(2'b10, pattern(81), pattern(82), '0);
        @(negedge clk); drive(1'b1, 2'b10, 1'b0, pattern(81), pattern(82), '0);
        @(negedge clk); drive(1'b1, bad_m, bad_vl, pattern(83), pattern(84), pattern(85));
        @(negedge clk); drive(1'b0, 2'b00, 1'b0, '0, '0, '0);
        chk("R6 legal first", out_result, good);
        @(negedge clk);
        chk("R6 undef flag", {255'd0, out_undef}, 256'd1);
        chk("R6 no valid", {255'd0, out_valid}, '0);
        chk("R6 result held", out_result, good);
        @(negedge clk);
        chk("R6 flag one cycle", {255'd0, out_undef}, '0);
    endtask

    task automatic t_idle_r9();
        logic [255:0] held;
        held = out_result;
        drive(1'b0, 2'b10, 1'b0, pattern(91), pattern(92), pattern(93));
        repeat (3) @(negedge clk);
        chk("R9 idle valid", {254'd0, out_valid, out_undef}, '0);
        chk("R9 idle hold", out_result, held);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_corner_r1();
        t_wide_r2();
        t_legacy_r3();
        t_ext_r4();
        t_stream_r5();
        t_undef_r6(2'b01, 1'b1);
        t_undef_r6(2'b11, 1'b0);
        t_idle_r9();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule